// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block turns parallel characters into an asynchronous serial stream. It runs from a clock at sixteen times the baud rate. A one-clock write pulse places a character into a single holding register. When the shift stage is idle, the character moves into it on the following clock. The shift stage then sends a low start bit, the data bits least significant first, an optional parity bit and one or more high stop bits. The line rests high between characters.

Framing is set by static inputs: a word-length code, a stop-bit select and three parity controls. These inputs are sampled at the moment a character enters the shift stage, so they apply to that whole character. A break input pulls the line low at once while it is high. The framing keeps running underneath, so the two status flags keep the same timing as without break. The holding-empty flag reports that the host may write. The transmitter-empty flag reports that both the holding register and the shift stage are empty.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `tx` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A write pulse stores `wr_data`, and `hold_empty` is 0 from the next cycle. If the shift stage is idle, the character moves into it on the following clock edge. `hold_empty` then returns to 1 unless another write comes in that same cycle.
- R3: A character starts with a start bit of 16 clocks at 0. Each data bit follows, least significant bit first, for 16 clocks. `tx` is 1 whenever no character is being sent and break is off.
- R4: `word_len` selects the number of data bits: 0→5, 1→6, 2→7, 3→8. Bits of the written byte above the selected length are never sent.
- R5: With `stop_sel`=0 the stop period is 16 clocks. With `stop_sel`=1 it is 24 clocks for 5-bit words and 32 clocks for 6, 7 or 8-bit words. Stop bits are 1.
- R6: With `par_en`=0, no parity bit is sent. With `par_en`=1, one 16-clock parity bit follows the data, chosen as follows:
  - `par_stick`=0 and `par_even`=0: odd parity over the sent data bits.
  - `par_stick`=0 and `par_even`=1: even parity over the sent data bits.
  - `par_stick`=1 and `par_even`=0: the bit is 1.
  - `par_stick`=1 and `par_even`=1: the bit is 0.
- R7: While `brk` is 1, `tx` is 0 in the same cycle. Framing continues underneath, and `hold_empty` and `tx_empty` keep their normal timing.
- R8: `tx_empty` is 1 only when the holding register is empty and no character is being shifted.
- R9: The framing inputs are sampled when a character enters the shift stage. Changing them during the character has no effect on it.
- R10: A write while the holding register is full replaces the held character. Only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16x the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-clock write pulse for the holding register |
| wr_data | input | 8 | Character to send |
| word_len | input | 2 | Data length code (0..3 → 5..8 bits) |
| stop_sel | input | 1 | Stop length select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even select; with stick, selects a forced 0 |
| par_stick | input | 1 | Forced parity value |
| brk | input | 1 | Hold the line low |
| tx | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Each of the four word lengths is sent with a byte whose upper bits are set. This shows whether truncation happens at the selected length. Both stop selects are tried with 5-bit and 8-bit words, which separates the 24-clock and 32-clock long stops. All four parity modes are tried with data of odd and of even weight, so odd, even, forced 1 and forced 0 each give a different bit. Back-to-back writes, an overwrite while full, a framing change in mid-character and break asserted in mid-character check the handover, the latching of the framing inputs and the override. In all of these cases the line and both flags are compared with the reference model on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_stage_e;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.full = 1'b0;
        if (wr_stb) begin
            hold_d.full = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign full = hold_q.full;
    assign data = hold_q.data;
endmodule

// File: rtl/tx_frame_calc.sv
module tx_frame_calc #(
    parameter int unsigned OVERSAMPLE = 16,
    localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE)
) (
    input  logic [1:0]       word_len,
    input  logic             stop_sel,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_stick,
    input  logic [7:0]       data,
    output logic [2:0]       last_idx,
    output logic             par_on,
    output logic             par_val,
    output logic [CNT_W-1:0] stop_last
);
    logic [7:0] masked;
    logic       ones_odd;

    assign last_idx = 3'd4 + {1'b0, word_len};

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            masked[i] = data[i] && (i <= int'(last_idx));
        end
    end

    assign ones_odd = ^masked;
    assign par_on   = par_en;
    assign par_val  = par_stick ? ~par_even : (par_even ? ones_odd : ~ones_odd);

    always_comb begin
        if (!stop_sel)            stop_last = CNT_W'(OVERSAMPLE - 1);
        else if (word_len == 2'd0) stop_last = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
        else                       stop_last = CNT_W'(2 * OVERSAMPLE - 1);
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_data,
    input  logic [2:0]       last_idx,
    input  logic             par_on,
    input  logic             par_val,
    input  logic [CNT_W-1:0] stop_last,
    output logic             busy,
    output logic             bit_out
);
    typedef struct packed {
        tx_stage_e        stage;
        logic [CNT_W-1:0] tick;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic [2:0]       last_idx;
        logic             par_on;
        logic             par_val;
        logic [CNT_W-1:0] stop_last;
    } shift_s;

    shift_s sh_d, sh_q;
    logic   tick_end;

    assign tick_end = (sh_q.stage == ST_STOP) ? (sh_q.tick == sh_q.stop_last)
                                              : (sh_q.tick == CNT_W'(OVERSAMPLE - 1));

    always_comb begin
        sh_d = sh_q;
        if (sh_q.stage == ST_IDLE) begin
            if (load) begin
                sh_d.stage     = ST_START;
                sh_d.tick      = '0;
                sh_d.idx       = '0;
                sh_d.sh        = load_data;
                sh_d.last_idx  = last_idx;
                sh_d.par_on    = par_on;
                sh_d.par_val   = par_val;
                sh_d.stop_last = stop_last;
            end
        end else if (!tick_end) begin
            sh_d.tick = sh_q.tick + 1'b1;
        end else begin
            sh_d.tick = '0;
            case (sh_q.stage)
                ST_START: sh_d.stage = ST_DATA;
                ST_DATA: begin
                    if (sh_q.idx == sh_q.last_idx) begin
                        sh_d.stage = sh_q.par_on ? ST_PAR : ST_STOP;
                    end else begin
                        sh_d.idx = sh_q.idx + 1'b1;
                        sh_d.sh  = sh_q.sh >> 1;
                    end
                end
                ST_PAR:  sh_d.stage = ST_STOP;
                default: sh_d.stage = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{stage: ST_IDLE, default: '0};
        else        sh_q <= sh_d;
    end

    always_comb begin
        case (sh_q.stage)
            ST_START: bit_out = 1'b0;
            ST_DATA:  bit_out = sh_q.sh[0];
            ST_PAR:   bit_out = sh_q.par_val;
            default:  bit_out = 1'b1;
        endcase
    end

    assign busy = (sh_q.stage != ST_IDLE);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic [1:0] word_len,
    input  logic       stop_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       brk,
    output logic       tx,
    output logic       hold_empty,
    output logic       tx_empty
);
    localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE);

    logic             hold_full;
    logic [7:0]       hold_data;
    logic             sh_busy;
    logic             sh_bit;
    logic             take;
    logic [2:0]       f_last_idx;
    logic             f_par_on;
    logic             f_par_val;
    logic [CNT_W-1:0] f_stop_last;

    assign take = hold_full && !sh_busy;

    tx_hold_reg #(.DATA_W(8)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    tx_frame_calc #(.OVERSAMPLE(OVERSAMPLE)) u_calc (
        .word_len  (word_len),
        .stop_sel  (stop_sel),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .data      (hold_data),
        .last_idx  (f_last_idx),
        .par_on    (f_par_on),
        .par_val   (f_par_val),
        .stop_last (f_stop_last)
    );

    tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_data (hold_data),
        .last_idx  (f_last_idx),
        .par_on    (f_par_on),
        .par_val   (f_par_val),
        .stop_last (f_stop_last),
        .busy      (sh_busy),
        .bit_out   (sh_bit)
    );

    assign tx         = brk ? 1'b0 : sh_bit;
    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !sh_busy;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic brk,
    input logic tx,
    input logic hold_empty,
    input logic tx_empty,
    input logic sh_busy
);
    AST_BRK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n) brk |-> !tx); // R7
    AST_EMPTY_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tx_empty |-> hold_empty); // R8
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (tx_empty && !brk) |-> tx); // R3
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !hold_empty); // R2
    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n) (!hold_empty && !sh_busy) |=> sh_busy); // R2
    AST_HANDOVER_FREES: assert property (@(posedge clk) disable iff (!rst_n) (!hold_empty && !sh_busy && !wr_stb) |=> hold_empty); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) ($rose(sh_busy) && !brk) |-> !tx); // R3
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (.*);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_len = 2'd3;
    logic       stop_sel = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       brk = 1'b0;
    logic       tx, hold_empty, tx_empty;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    uart_tx_core dut (.*);

    // behavioural reference: holding flag plus a per-clock queue of line levels
    bit       m_full = 0;
    bit [7:0] m_data = 0;
    bit       m_line[$];

    function automatic void build_frame(bit [7:0] d);
        int n;
        int ones;
        bit pv;
        int stop_len;
        n = 5 + int'(word_len);
        ones = 0;
        for (int k = 0; k < 16; k++) m_line.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            if (d[i]) ones++;
            for (int k = 0; k < 16; k++) m_line.push_back(d[i]);
        end
        if (par_en) begin
            if (par_stick) pv = !par_even;
            else if (par_even) pv = (ones % 2) == 1;
            else pv = (ones % 2) == 0;
            for (int k = 0; k < 16; k++) m_line.push_back(pv);
        end
        stop_len = !stop_sel ? 16 : (word_len == 2'd0 ? 24 : 32);
        for (int k = 0; k < stop_len; k++) m_line.push_back(1'b1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_full = 0;
            m_line.delete();
        end else begin
            bit was_busy;
            was_busy = m_line.size() > 0;
            if (was_busy) void'(m_line.pop_front());
            if (!was_busy && m_full) begin
                build_frame(m_data);
                m_full = 0;
            end
            if (wr_stb) begin
                m_full = 1;
                m_data = wr_data;
            end
        end
    end

    task automatic check(string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual %b expected %b", cur_tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_tx;
            e_tx = brk ? 1'b0 : (m_line.size() > 0 ? m_line[0] : 1'b1);
            check("tx", tx, e_tx);
            check("hold_empty", hold_empty, !m_full);
            check("tx_empty", tx_empty, !m_full && m_line.size() == 0);
        end
    end

    task automatic put(logic [7:0] d);
        do @(negedge clk); while (!hold_empty);
        @(posedge clk); #1;
        wr_stb = 1'b1;
        wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (!tx_empty);
        @(posedge clk); #1;
    endtask

    task automatic cfg(logic [1:0] wl, logic sb, logic pe, logic ev, logic st);
        word_len = wl; stop_sel = sb; par_en = pe; par_even = ev; par_stick = st;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R1";
        check("reset tx", tx, 1'b1);
        check("reset hold_empty", hold_empty, 1'b1);
        check("reset tx_empty", tx_empty, 1'b1);

        // R3 R4: every word length, upper bits set to expose truncation
        cur_tag = "R4";
        for (int wl = 0; wl < 4; wl++) begin
            cfg(wl[1:0], 1'b0, 1'b0, 1'b0, 1'b0);
            put(8'hE5);
            drain();
        end
        cur_tag = "R3";
        cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        put(8'h01);
        drain();

        // R5: long stop with 5-bit and 8-bit words
        cur_tag = "R5";
        cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b0); put(8'h15); drain();
        cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0); put(8'hA3); drain();
        cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b0); put(8'h2C); drain();

        // R6: four parity modes, odd and even weight data
        cur_tag = "R6";
        for (int m = 0; m < 4; m++) begin
            cfg(2'd3, 1'b0, 1'b1, m[0], m[1]);
            put(8'h07); drain();
            put(8'h03); drain();
        end

        // R2 R8: back-to-back writes
        cur_tag = "R2";
        cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        put(8'h5A);
        put(8'h3C);
        cur_tag = "R8";
        put(8'h66);
        drain();

        // R10: overwrite while holding register is full
        cur_tag = "R10";
        cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        put(8'h11);
        put(8'h22);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = 8'h99;
        @(posedge clk); #1;
        wr_stb = 1'b0;
        drain();

        // R9: framing inputs change in the middle of a character
        cur_tag = "R9";
        cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        put(8'hC3);
        repeat (40) @(posedge clk);
        #1 cfg(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        drain();

        // R7: break during a character, then released
        cur_tag = "R7";
        cfg(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
        put(8'hFF);
        put(8'h81);
        repeat (30) @(posedge clk);
        #1 brk = 1'b1;
        repeat (200) @(posedge clk);
        #1 brk = 1'b0;
        drain();
        repeat (5) @(posedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule